// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block turns a slow step clock into the four drive signals of a unipolar two-phase stepping motor. Each rising edge of the step clock moves the winding pattern one position, forward or backward. The motor speed therefore follows the step clock frequency. Two excitation schemes are available: full-step, with two windings always on, and half-step, where one-winding and two-winding states alternate. The scheme is read at every step edge, so it can change while the motor runs.

All control inputs are asynchronous to the fast system clock. Each one passes through a two-flop synchroniser, and the step edge is detected in the system clock domain. A low level on the drive-reset input switches every winding off and returns the sequencer to its home pattern. When drive-reset is released, the first pattern is A with BB. A low level on the enable input blanks all windings and freezes the position. Stepping then resumes from that same position once enable returns high.

Top module: `stepper_phase_seq`

## Requirements
- R1: After system reset, with drive_rst_n held low, all four coil outputs are 0.
- R2: While drive_rst_n is low, all coils are 0 and the position returns to home. Within 4 clocks after drive_rst_n goes high, the coils read {a,ab,b,bb}=1001, which is A with BB.
- R3: With half_step=0 and reverse=0, successive rising edges of step_clk give {a,ab,b,bb} = 1001, 1010, 0110, 0101, then 1001 again.
- R4: With half_step=0 and reverse=1, the full-step patterns of R3 run in the opposite order: 1001, 0101, 0110, 1010.
- R5: With half_step=1 and reverse=0, successive edges give the 8-state order 1001, 1000, 1010, 0010, 0110, 0100, 0101, 0001, then 1001 again.
- R6: With half_step=1 and reverse=1, the R5 order runs backwards, one state per edge.
- R7: coil_a and coil_ab are never both 1, and coil_b and coil_bb are never both 1.
- R8: While enable is low, all coils are 0 and step edges are ignored. After enable returns high, the coils show the pattern held before enable went low, and the next edge advances from that pattern.
- R9: half_step is sampled at each step edge. A full-step edge taken from a one-winding state (1000, 0010, 0100, 0001) moves to the next two-winding state in the current direction.
- R10: A half-step edge taken from a two-winding state moves exactly one position in the R5 order, in the current direction.
- R11: Step edges that arrive while drive_rst_n is low are ignored. After release, the pattern is 1001.
- R12: The position changes only on a rising step_clk edge. A falling edge leaves the coils unchanged. The output follows a rising edge within 4 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously |
| step_clk | input | 1 | Asynchronous step clock; each rising edge advances one step |
| half_step | input | 1 | 0: full-step two-winding excitation; 1: half-step excitation |
| reverse | input | 1 | 0: forward (CW); 1: reverse (CCW) |
| drive_rst_n | input | 1 | Active-low drive reset: coils off, position to home |
| enable | input | 1 | 0: coils forced off and position frozen |
| coil_a | output | 1 | Winding A drive |
| coil_ab | output | 1 | Winding A-bar drive |
| coil_b | output | 1 | Winding B drive |
| coil_bb | output | 1 | Winding B-bar drive |

## Verification
The hardest situation to reach is a full-step edge taken from a one-winding state. That state exists only after half-step stepping has stopped on an odd position. The stimulus first makes one half-step move from home, then lowers half_step before the next edge and checks that the coils land on the following two-winding pattern in each direction. Edges sent while enable is low or drive reset is low are also checked at the coils, once the blocking input is released.

// File: rtl/stepper_pkg.sv
package stepper_pkg;
  localparam int POS_W = 3;
  typedef logic [POS_W-1:0] pos_t;

  typedef struct packed {
    logic a;
    logic ab;
    logic b;
    logic bb;
  } coil_t;

  // Even positions are two-winding states, odd positions are one-winding states
  function automatic coil_t pos_decode(pos_t p);
    coil_t c;
    case (p)
      3'd0:    c = '{a:1'b1, ab:1'b0, b:1'b0, bb:1'b1};
      3'd1:    c = '{a:1'b1, ab:1'b0, b:1'b0, bb:1'b0};
      3'd2:    c = '{a:1'b1, ab:1'b0, b:1'b1, bb:1'b0};
      3'd3:    c = '{a:1'b0, ab:1'b0, b:1'b1, bb:1'b0};
      3'd4:    c = '{a:1'b0, ab:1'b1, b:1'b1, bb:1'b0};
      3'd5:    c = '{a:1'b0, ab:1'b1, b:1'b0, bb:1'b0};
      3'd6:    c = '{a:1'b0, ab:1'b1, b:1'b0, bb:1'b1};
      default: c = '{a:1'b0, ab:1'b0, b:1'b0, bb:1'b1};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/step_edge.sv
module step_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/phase_pos.sv
module phase_pos
  import stepper_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic home,
  input  logic advance,
  input  logic half,
  input  logic rev,
  output pos_t pos_q
);
  pos_t stride;
  pos_t pos_d;

  always_comb begin
    // full-step from a one-winding state moves one place to reach a two-winding state
    stride = (half || pos_q[0]) ? pos_t'(1) : pos_t'(2);
    pos_d  = pos_q;
    if (home)         pos_d = '0;
    else if (advance) pos_d = rev ? pos_q - stride : pos_q + stride;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end
endmodule

// File: rtl/coil_drive.sv
module coil_drive
  import stepper_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  active,
  input  pos_t  pos,
  output coil_t coil_q
);
  coil_t coil_d;

  always_comb begin
    coil_d = active ? pos_decode(pos) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coil_q <= '0;
    else        coil_q <= coil_d;
  end
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
  import stepper_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_clk,
  input  logic half_step,
  input  logic reverse,
  input  logic drive_rst_n,
  input  logic enable,
  output logic coil_a,
  output logic coil_ab,
  output logic coil_b,
  output logic coil_bb
);
  localparam int N_IN = 5;

  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  logic [N_IN-1:0] in_s;
  logic step_s, half_s, rev_s, drst_s, en_s;

  seq_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     ({step_clk, half_step, reverse, drive_rst_n, enable}),
    .q     (in_s)
  );
  assign {step_s, half_s, rev_s, drst_s, en_s} = in_s;

  logic step_pulse;
  step_edge u_edge (
    .clk   (clk),
    .rst_n (rst_sn),
    .lvl   (step_s),
    .rise  (step_pulse)
  );

  pos_t  pos_q;
  logic  advance;
  assign advance = step_pulse & en_s & drst_s;

  phase_pos u_pos (
    .clk     (clk),
    .rst_n   (rst_sn),
    .home    (~drst_s),
    .advance (advance),
    .half    (half_s),
    .rev     (rev_s),
    .pos_q   (pos_q)
  );

  coil_t coil_q;
  coil_drive u_drive (
    .clk    (clk),
    .rst_n  (rst_sn),
    .active (drst_s & en_s),
    .pos    (pos_q),
    .coil_q (coil_q)
  );

  assign coil_a  = coil_q.a;
  assign coil_ab = coil_q.ab;
  assign coil_b  = coil_q.b;
  assign coil_bb = coil_q.bb;
endmodule

// File: rtl/stepper_phase_seq_chk.sv
module stepper_phase_seq_chk (
  input logic       clk,
  input logic       rst_sn,
  input logic       step_pulse,
  input logic       half_s,
  input logic       rev_s,
  input logic       drst_s,
  input logic       en_s,
  input logic [2:0] pos_q,
  input logic       coil_a,
  input logic       coil_ab,
  input logic       coil_b,
  input logic       coil_bb
);
  p_coil_excl_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    !(coil_a && coil_ab) && !(coil_b && coil_bb));

  p_drst_off_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    !drst_s |=> !(coil_a || coil_ab || coil_b || coil_bb));

  p_drst_home_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    !drst_s |=> pos_q == 3'd0);

  p_en_off_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    !en_s |=> !(coil_a || coil_ab || coil_b || coil_bb));

  p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (drst_s && !en_s) |=> $stable(pos_q));

  p_no_edge_hold_r12: assert property (@(posedge clk) disable iff (!rst_sn)
    (drst_s && !step_pulse) |=> $stable(pos_q));

  p_full_lands_even_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (step_pulse && en_s && drst_s && !half_s) |=> !pos_q[0]);

  p_half_fwd_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (step_pulse && en_s && drst_s && half_s && !rev_s) |=> pos_q == 3'($past(pos_q) + 3'd1));

  p_half_rev_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (step_pulse && en_s && drst_s && half_s && rev_s) |=> pos_q == 3'($past(pos_q) - 3'd1));
endmodule

bind stepper_phase_seq stepper_phase_seq_chk u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .step_pulse (step_pulse),
  .half_s     (half_s),
  .rev_s      (rev_s),
  .drst_s     (drst_s),
  .en_s       (en_s),
  .pos_q      (pos_q),
  .coil_a     (coil_a),
  .coil_ab    (coil_ab),
  .coil_b     (coil_b),
  .coil_bb    (coil_bb)
);

// File: tb/stepper_phase_seq_bench.sv
module stepper_phase_seq_bench;
  logic clk = 1'b0;
  logic rst_n, step_clk, half_step, reverse, drive_rst_n, enable;
  logic coil_a, coil_ab, coil_b, coil_bb;
  int   n_checks = 0;
  int   n_fails  = 0;
  int   idx      = 0;

  always #4 clk = ~clk;

  stepper_phase_seq u_stepper_phase_seq (
    .clk(clk), .rst_n(rst_n), .step_clk(step_clk), .half_step(half_step),
    .reverse(reverse), .drive_rst_n(drive_rst_n), .enable(enable),
    .coil_a(coil_a), .coil_ab(coil_ab), .coil_b(coil_b), .coil_bb(coil_bb)
  );

  // expected {a,ab,b,bb} for half-step index, from the R5 order
  function automatic logic [3:0] pat(int i);
    case (i & 7)
      0: return 4'b1001;
      1: return 4'b1000;
      2: return 4'b1010;
      3: return 4'b0010;
      4: return 4'b0110;
      5: return 4'b0100;
      6: return 4'b0101;
      default: return 4'b0001;
    endcase
  endfunction

  task automatic check(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {coil_a, coil_ab, coil_b, coil_bb};
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: coils act=%b exp=%b", req, act, exp);
    end
    // R7: opposite windings never on together
    n_checks++;
    if ((act[3] && act[2]) || (act[1] && act[0])) begin
      n_fails++;
      $display("FAIL R7: coils act=%b exp=no opposing pair", act);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // one step edge with the given mode and direction; the model tracks the position
  task automatic do_step(logic half, logic rev, logic counts);
    half_step = half;
    reverse   = rev;
    wait_cyc(4);
    step_clk = 1'b1;
    wait_cyc(8);
    step_clk = 1'b0;
    wait_cyc(8);
    if (counts) begin
      if (half || (idx % 2 == 1)) idx = rev ? idx + 7 : idx + 1;
      else                        idx = rev ? idx + 6 : idx + 2;
      idx = idx % 8;
    end
  endtask

  task automatic t_reset();
    check("R1", 4'b0000);
  endtask

  task automatic t_home();
    drive_rst_n = 1'b1;
    wait_cyc(6);
    idx = 0;
    check("R2", pat(0));
  endtask

  task automatic t_full_fwd();
    for (int k = 0; k < 5; k++) begin
      do_step(1'b0, 1'b0, 1'b1);
      check("R3", pat(idx));
    end
  endtask

  task automatic t_full_rev();
    for (int k = 0; k < 4; k++) begin
      do_step(1'b0, 1'b1, 1'b1);
      check("R4", pat(idx));
    end
  endtask

  task automatic t_half_fwd();
    for (int k = 0; k < 9; k++) begin
      do_step(1'b1, 1'b0, 1'b1);
      check("R5", pat(idx));
    end
  endtask

  task automatic t_half_rev();
    for (int k = 0; k < 8; k++) begin
      do_step(1'b1, 1'b1, 1'b1);
      check("R6", pat(idx));
    end
  endtask

  task automatic t_enable();
    logic [3:0] held;
    do_step(1'b1, 1'b0, 1'b1);
    held = pat(idx);
    enable = 1'b0;
    wait_cyc(6);
    check("R8", 4'b0000);
    do_step(1'b1, 1'b0, 1'b0);
    do_step(1'b1, 1'b0, 1'b0);
    check("R8", 4'b0000);
    enable = 1'b1;
    wait_cyc(6);
    check("R8", held);
    do_step(1'b1, 1'b0, 1'b1);
    check("R8", pat(idx));
  endtask

  task automatic t_mode_switch();
    if (idx % 2 == 0) do_step(1'b1, 1'b0, 1'b1);
    check("R9", pat(idx));
    do_step(1'b0, 1'b0, 1'b1);
    check("R9", pat(idx));
    do_step(1'b1, 1'b1, 1'b1);
    do_step(1'b0, 1'b1, 1'b1);
    check("R9", pat(idx));
  endtask

  task automatic t_full_to_half();
    do_step(1'b0, 1'b0, 1'b1);
    do_step(1'b1, 1'b0, 1'b1);
    check("R10", pat(idx));
    do_step(1'b0, 1'b0, 1'b1);
    do_step(1'b1, 1'b1, 1'b1);
    check("R10", pat(idx));
  endtask

  task automatic t_rst_ignore();
    do_step(1'b0, 1'b0, 1'b1);
    drive_rst_n = 1'b0;
    wait_cyc(6);
    check("R11", 4'b0000);
    do_step(1'b1, 1'b0, 1'b0);
    do_step(1'b0, 1'b0, 1'b0);
    drive_rst_n = 1'b1;
    wait_cyc(6);
    idx = 0;
    check("R11", pat(0));
  endtask

  task automatic t_edge_only();
    half_step = 1'b1;
    reverse   = 1'b0;
    wait_cyc(4);
    step_clk = 1'b1;
    wait_cyc(5);
    idx = (idx + 1) % 8;
    check("R12", pat(idx));
    step_clk = 1'b0;
    wait_cyc(10);
    check("R12", pat(idx));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: act=timeout exp=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; step_clk = 1'b0; half_step = 1'b0; reverse = 1'b0;
    drive_rst_n = 1'b0; enable = 1'b1;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(6);
    t_reset();
    t_home();
    t_full_fwd();
    t_full_rev();
    t_half_fwd();
    t_half_rev();
    t_enable();
    t_mode_switch();
    t_full_to_half();
    t_rst_ignore();
    t_edge_only();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule